// File: doc/BRIEF.md
# Receiver Duty-Cycle Wake-Up Sequencer

This block runs the power cycle of a low-power radio receiver. A host microcontroller shifts a 9-bit setup word in one bit at a time and commits it with a load strobe. The word holds a front-end gain flag, a band choice and a 6-bit sleep code. The sequencer then loops through four phases. It sleeps for a programmed interval, turns on the crystal oscillator and waits for it to settle, and enables the receiver for a detection window. If the demodulator reports a sync pattern in that window, the receiver stays on for as long as useful data keeps arriving.

All durations are counted in periods of a timebase tick input, nominally 10 µs. On a good sync the host gets a short interrupt pulse. If the window runs out with no sync, everything is powered down again without an interrupt. A 2-bit state output shows the current phase: 0 sleep, 1 settle, 2 detect, 3 receive.

Top module: `rx_wake_seq`

## Requirements
- R1: Serial bits shift in on `cfg_shift`, first bit first. After exactly 9 shifts, `cfg_load` commits the word: bit 0 to `lna_atten` (0 = high gain, 1 = reduced gain), bits 2:1 to `band` (bit 2 is the MSB), and bits 8:3 to `sleep_code` (bit 8 is the MSB).
- R2: A `cfg_load` after any shift count other than 9 leaves all three configuration outputs unchanged.
- R3: A committed band value of 2'b11 is reserved. It leaves `band` at its previous value while the other fields still update, so `band` never reads 2'b11.
- R4: In sleep (state 0), `osc_en` and `rx_en` are low. For a nonzero `sleep_code` N, sleep lasts (N+1)·TICKS_20MS ticks.
- R5: When `sleep_code` is 0, sleep lasts 148·BIT_TICKS ticks.
- R6: Settle (state 1) follows sleep and lasts SETTLE_TICKS ticks with `osc_en` high and `rx_en` low. Detect is entered only from settle.
- R7: `win_sel` is sampled when detect starts and sets the window length: 00 gives WIN_NOM_TICKS, 01 gives WIN_MID_TICKS, 10 gives WIN_LONG_TICKS, and 11 gives WIN_NOM_TICKS. When the window expires without sync, the block returns to sleep with no interrupt.
- R8: `sync_det` high in detect moves the block to receive (state 3) on the next clock. It also raises `irq` for exactly IRQ_TICKS ticks. This holds even on the window's last tick.
- R9: Receive lasts HOLD_TICKS ticks after entry or after the most recent `data_vld`. The block then returns to sleep.
- R10: `sync_det` outside detect, and `data_vld` outside receive, have no effect on state, timing or `irq`.
- R11: After reset the block is in sleep with `osc_en`, `rx_en` and `irq` low, and `lna_atten`, `band` and `sleep_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe, one clock wide |
| cfg_shift | input | 1 | Shift `cfg_din` into the setup register |
| cfg_din | input | 1 | Serial setup data |
| cfg_load | input | 1 | Commit the shifted word |
| win_sel | input | 2 | Detection window choice |
| sync_det | input | 1 | Sync pattern found strobe |
| data_vld | input | 1 | Useful data received strobe |
| osc_en | output | 1 | Crystal oscillator enable |
| rx_en | output | 1 | Receiver enable |
| irq | output | 1 | Host interrupt pulse |
| state | output | 2 | Phase: 0 sleep, 1 settle, 2 detect, 3 receive |
| lna_atten | output | 1 | Front-end gain reduced when high |
| band | output | 2 | Selected band |
| sleep_code | output | 6 | Active sleep code |

## Verification
The bench measures the length of every phase and counts interrupt cycles in each, so every phase is checked separately. Four passes with no sync, one per `win_sel` code, tell the three window lengths apart and show that code 11 falls back to the nominal window. Separate receive passes cover several cases: a mid-window sync, a sync in the first detect cycle with two data restarts, and a sync on the window's final tick. Stray strobes in the wrong phase must leave the phase lengths and interrupt counts unchanged. The setup register is loaded with 8, 9 and 10 shifts and with the reserved band code, and the bench compares all three fields after each load.

// File: rtl/rx_wake_seq.sv
module rx_wake_seq #(
  parameter int unsigned TICKS_20MS     = 2000,
  parameter int unsigned BIT_TICKS      = 10,
  parameter int unsigned SETTLE_TICKS   = 500,
  parameter int unsigned WIN_NOM_TICKS  = 1228,
  parameter int unsigned WIN_MID_TICKS  = 2608,
  parameter int unsigned WIN_LONG_TICKS = 6444,
  parameter int unsigned HOLD_TICKS     = 3000,
  parameter int unsigned IRQ_TICKS      = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_shift,
  input  logic       cfg_din,
  input  logic       cfg_load,
  input  logic [1:0] win_sel,
  input  logic       sync_det,
  input  logic       data_vld,
  output logic       osc_en,
  output logic       rx_en,
  output logic       irq,
  output logic [1:0] state,
  output logic       lna_atten,
  output logic [1:0] band,
  output logic [5:0] sleep_code
);
  localparam int unsigned CW = 9;
  localparam int unsigned SHORT_BITS = 148;
  localparam int unsigned TMAX = 64 * TICKS_20MS + SHORT_BITS * BIT_TICKS + SETTLE_TICKS
                               + WIN_NOM_TICKS + WIN_MID_TICKS + WIN_LONG_TICKS + HOLD_TICKS;
  localparam int TW = $clog2(TMAX + 1);
  localparam int IW = $clog2(IRQ_TICKS + 1);
  localparam logic [1:0] ST_SLEEP = 2'd0, ST_SETTLE = 2'd1, ST_DETECT = 2'd2, ST_RECV = 2'd3;

  logic [CW-1:0] sr;
  logic [3:0]    nbits;
  logic [1:0]    st, st_nxt, win_q;
  logic [TW-1:0] tmr, lim, win_lim;
  logic [IW-1:0] irq_cnt;
  logic          done, sync_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr         <= '0;
      nbits      <= '0;
      lna_atten  <= 1'b0;
      band       <= 2'b00;
      sleep_code <= '0;
    end else if (cfg_load) begin
      nbits <= '0;
      if (nbits == 4'd9) begin
        lna_atten  <= sr[0];
        if (sr[2:1] != 2'b11) band <= sr[2:1];
        sleep_code <= sr[8:3];
      end
    end else if (cfg_shift) begin
      sr <= {cfg_din, sr[CW-1:1]};
      if (nbits != 4'hF) nbits <= nbits + 4'd1;
    end
  end

  always_comb begin
    case (win_q)
      2'b01:   win_lim = TW'(WIN_MID_TICKS);
      2'b10:   win_lim = TW'(WIN_LONG_TICKS);
      default: win_lim = TW'(WIN_NOM_TICKS);
    endcase
  end

  always_comb begin
    case (st)
      ST_SLEEP:  lim = (sleep_code == '0) ? TW'(SHORT_BITS * BIT_TICKS)
                                          : TW'(TICKS_20MS) * (TW'(sleep_code) + TW'(1));
      ST_SETTLE: lim = TW'(SETTLE_TICKS);
      ST_DETECT: lim = win_lim;
      default:   lim = TW'(HOLD_TICKS);
    endcase
  end

  always_comb begin
    case (st)
      ST_SLEEP:  st_nxt = ST_SETTLE;
      ST_SETTLE: st_nxt = ST_DETECT;
      default:   st_nxt = ST_SLEEP;
    endcase
  end

  assign done     = tick && (tmr >= lim - TW'(1));
  assign sync_hit = (st == ST_DETECT) && sync_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_SLEEP;
      tmr   <= '0;
      win_q <= 2'b00;
    end else if (sync_hit) begin
      st  <= ST_RECV;
      tmr <= '0;
    end else if (st == ST_RECV && data_vld) begin
      tmr <= '0;
    end else if (done) begin
      st  <= st_nxt;
      tmr <= '0;
      if (st == ST_SETTLE) win_q <= win_sel;
    end else if (tick) begin
      tmr <= tmr + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    irq_cnt <= '0;
    else if (sync_hit)             irq_cnt <= IW'(IRQ_TICKS);
    else if (tick && irq_cnt != 0) irq_cnt <= irq_cnt - IW'(1);
  end

  assign state  = st;
  assign osc_en = (st != ST_SLEEP);
  assign rx_en  = (st == ST_DETECT) || (st == ST_RECV);
  assign irq    = (irq_cnt != '0);
endmodule

// File: rtl/rx_wake_seq_chk.sv
module rx_wake_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_det,
  input logic       data_vld,
  input logic       osc_en,
  input logic       rx_en,
  input logic       irq,
  input logic [1:0] state,
  input logic [1:0] band
);
  AST_SLEEP_POWERED_DOWN: assert property (@(posedge clk) disable iff (!rst_n) state == 2'd0 |-> !osc_en && !rx_en); // R4
  AST_SETTLE_OSC_ONLY: assert property (@(posedge clk) disable iff (!rst_n) state == 2'd1 |-> osc_en && !rx_en); // R6
  AST_RX_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n) rx_en |-> osc_en); // R6
  AST_DETECT_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n) (state == 2'd2 && $past(state) != 2'd2) |-> $past(state) == 2'd1); // R6
  AST_SYNC_TO_RECV: assert property (@(posedge clk) disable iff (!rst_n) (state == 2'd2 && sync_det) |=> (state == 2'd3 && irq)); // R8
  AST_RECV_FROM_DETECT: assert property (@(posedge clk) disable iff (!rst_n) (state == 2'd3 && $past(state) != 2'd3) |-> $past(state) == 2'd2); // R8
  AST_IRQ_IN_RECV: assert property (@(posedge clk) disable iff (!rst_n) irq |-> state == 2'd3); // R8
  AST_DATA_HOLDS_RECV: assert property (@(posedge clk) disable iff (!rst_n) (state == 2'd3 && data_vld) |=> state == 2'd3); // R9
  AST_BAND_NOT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n) band != 2'b11); // R3
endmodule

bind rx_wake_seq rx_wake_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_det(sync_det), .data_vld(data_vld),
  .osc_en(osc_en), .rx_en(rx_en), .irq(irq), .state(state), .band(band)
);

// File: tb/tb_rx_wake_seq.sv
module tb_rx_wake_seq;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic cfg_shift = 1'b0, cfg_din = 1'b0, cfg_load = 1'b0;
  logic [1:0] win_sel = 2'b00;
  logic sync_det = 1'b0, data_vld = 1'b0;
  logic osc_en, rx_en, irq, lna_atten;
  logic [1:0] state, band;
  logic [5:0] sleep_code;

  int vecs = 0, errs = 0;
  int exp_st[$], exp_len[$], exp_irq[$];
  string exp_req[$];

  always #10 clk = ~clk;

  rx_wake_seq #(
    .TICKS_20MS(20), .BIT_TICKS(2), .SETTLE_TICKS(5), .WIN_NOM_TICKS(12),
    .WIN_MID_TICKS(26), .WIN_LONG_TICKS(64), .HOLD_TICKS(30), .IRQ_TICKS(5)
  ) dut (.*);

  task automatic check(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(int s, int l, int i, string req);
    exp_st.push_back(s); exp_len.push_back(l); exp_irq.push_back(i); exp_req.push_back(req);
  endtask

  task automatic wait_state(int s);
    do @(negedge clk); while (state != 2'(s));
  endtask

  task automatic load_cfg(logic [15:0] w, int n);
    for (int i = 0; i < n; i++) begin
      cfg_din = w[i]; cfg_shift = 1'b1; @(negedge clk);
    end
    cfg_shift = 1'b0; cfg_load = 1'b1; @(negedge clk);
    cfg_load = 1'b0; @(negedge clk);
  endtask

  // monitor: measures each phase length and interrupt cycles, compares with the queue
  int cur = 0, len = 0, irqn = 0;
  bit first = 1'b1;
  always @(negedge clk) if (rst_n) begin
    if (int'(state) == cur) begin
      len++; irqn += int'(irq);
    end else begin
      if (first) first = 1'b0;
      else if (exp_st.size() == 0) check("R4 unexpected phase", cur, -1);
      else begin
        string r = exp_req.pop_front();
        check({r, " phase"}, cur, exp_st.pop_front());
        check({r, " length"}, len, exp_len.pop_front());
        check({r, " irq cycles"}, irqn, exp_irq.pop_front());
      end
      cur = int'(state); len = 1; irqn = int'(irq);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog expired", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    push(1, 5, 0, "R6"); push(2, 12, 0, "R7 win00"); push(0, 40, 0, "R4"); push(1, 5, 0, "R6");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 state", state, 0); check("R11 osc_en", osc_en, 0); check("R11 rx_en", rx_en, 0);
    check("R11 irq", irq, 0); check("R11 lna_atten", lna_atten, 0);
    check("R11 band", band, 0); check("R11 sleep_code", sleep_code, 0);
    // R1 word: lna=1, band=01, sleep=2
    load_cfg(16'h0013, 9);
    check("R1 lna_atten", lna_atten, 1); check("R1 band", band, 1); check("R1 sleep_code", sleep_code, 2);
    // R2 wrong counts discarded
    load_cfg(16'h01F0, 8);
    check("R2 8 bits lna", lna_atten, 1); check("R2 8 bits band", band, 1); check("R2 8 bits sleep", sleep_code, 2);
    load_cfg(16'h03E0, 10);
    check("R2 10 bits lna", lna_atten, 1); check("R2 10 bits band", band, 1); check("R2 10 bits sleep", sleep_code, 2);
    // R3 reserved band keeps band, others update
    load_cfg(16'h000E, 9);
    check("R3 lna", lna_atten, 0); check("R3 band kept", band, 1); check("R3 sleep", sleep_code, 1);
    load_cfg(16'h000C, 9);
    check("R3 band 10", band, 2); check("R3 sleep", sleep_code, 1);

    // phase A: window 00 (items pushed at start)
    wait_state(2); wait_state(0);
    win_sel = 2'b01;
    push(2, 26, 0, "R7 win01"); push(0, 40, 0, "R4"); push(1, 5, 0, "R6");
    wait_state(2); wait_state(0);
    win_sel = 2'b10;
    push(2, 64, 0, "R7 win10"); push(0, 40, 0, "R4"); push(1, 5, 0, "R6");
    wait_state(2); wait_state(0);
    win_sel = 2'b11;
    push(2, 12, 0, "R7 win11"); push(0, 40, 0, "R4"); push(1, 5, 0, "R6");
    wait_state(2); wait_state(0);
    win_sel = 2'b00;

    // phase E: stray data in detect, sync at detect cycle 4, stray strobes in sleep
    push(2, 4, 0, "R8 R10"); push(3, 30, 5, "R8 R9"); push(0, 40, 0, "R10"); push(1, 5, 0, "R6");
    wait_state(2);
    data_vld = 1'b1; @(negedge clk); data_vld = 1'b0;
    @(negedge clk); @(negedge clk);
    sync_det = 1'b1; @(negedge clk); sync_det = 1'b0;
    wait_state(0);
    sync_det = 1'b1; data_vld = 1'b1; @(negedge clk); sync_det = 1'b0; data_vld = 1'b0;

    // phase F: sync in first detect cycle, data restarts at receive cycles 10 and 25, stray sync at 40
    push(2, 1, 0, "R8"); push(3, 55, 5, "R9 R10"); push(0, 40, 0, "R4"); push(1, 5, 0, "R6");
    wait_state(2);
    sync_det = 1'b1; @(negedge clk); sync_det = 1'b0;
    repeat (9) @(negedge clk);
    data_vld = 1'b1; @(negedge clk); data_vld = 1'b0;
    repeat (14) @(negedge clk);
    data_vld = 1'b1; @(negedge clk); data_vld = 1'b0;
    repeat (15) @(negedge clk);
    sync_det = 1'b1; @(negedge clk); sync_det = 1'b0;

    // phase G: sync on last window tick, then sleep code 0 for the short interval
    push(2, 12, 0, "R8 last tick"); push(3, 30, 5, "R9"); push(0, 296, 0, "R5"); push(1, 5, 0, "R6");
    wait_state(2);
    repeat (11) @(negedge clk);
    sync_det = 1'b1; @(negedge clk); sync_det = 1'b0;
    load_cfg(16'h0004, 9);
    check("R5 sleep_code zero", sleep_code, 0); check("R1 band 10", band, 2);

    push(2, 12, 0, "R7 win00");
    wait_state(2); wait_state(0);
    repeat (3) @(negedge clk);
    check("R4 queue drained", exp_st.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule